// File: doc/BRIEF.md
# Presettable Down-Counter Frequency Divider

This block is a programmable divider for the feedback path of an integer-N frequency synthesizer. It holds an 8-bit count register. The register steps down by one on each rising edge of the count-pulse clock. When the active-low preset-enable is low, the edge loads a divide word from a parallel port instead of taking a count step. An active-low terminal-count output is low whenever the register holds zero.

With the terminal count routed back to preset-enable, the counter reloads on the pulse that follows zero. The output therefore repeats every N+1 input pulses, so a word of 99 divides by 100. An input chooses between this internal feedback and an external preset-enable pin. A mode input chooses plain binary counting or two cascaded decimal digits. A registered divided-clock output toggles once per terminal count.

Top module: `pdiv_counter`

## Requirements
- R1: With `fb_sel`=0 and `load_n_ext`=0, a rising clock edge loads `div_word` into `count_q` in place of a count step.
- R2: With `bcd_mode`=0 and no load, each rising edge lowers `count_q` by one, and 0x00 wraps to 0xFF.
- R3: `tc_n` is 0 exactly while `count_q` is zero and 1 otherwise.
- R4: With `fb_sel`=1, the edge that follows a zero count reloads `div_word`, so `tc_n` goes low once every N+1 edges. A word of 99 gives a spacing of 100 edges.
- R5: With `bcd_mode`=1, bits [3:0] hold the units digit and bits [7:4] the tens digit. The units digit steps 0 to 9 and borrows one from the tens digit. Without a load, 0x00 steps to 0x99.
- R6: With `fb_sel`=1 and `div_word`=0, `count_q` stays 0 and `tc_n` stays low on every edge (divide-by-1).
- R7: An edge with `rst`=1 loads `div_word` into `count_q` and clears `div_out`. After reset in feedback mode, `tc_n` first goes low N edges later, and the reload happens on edge N+1.
- R8: `div_out` inverts on each edge at which `tc_n` was low, and holds its value on every other edge.
- R9: With `fb_sel`=1, `load_n_ext` has no effect on `count_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count-pulse clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; loads the divide word |
| bcd_mode | input | 1 | 1 = two decimal digits, 0 = binary |
| fb_sel | input | 1 | 1 = terminal count drives preset-enable, 0 = external pin drives it |
| load_n_ext | input | 1 | External active-low preset-enable |
| div_word | input | 8 | Parallel divide word N |
| tc_n | output | 1 | Active-low terminal count |
| count_q | output | 8 | Current count value |
| div_out | output | 1 | Registered divided clock, toggles per terminal count |

## Verification
The bench measures the spacing between terminal counts for a word of 99 in feedback mode. A design that divides by N instead of N+1 would report 99. It drives a word of zero, where a design that decrements before reloading would wrap to 0xFF and release `tc_n`. It runs decimal counts through the 00 boundary, where a decrementer that used binary borrow would produce 0xFF or 0x?F digits instead of 0x99. It also holds the external preset pin low while feedback is selected, so that a bad multiplexer would freeze the count on the word.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
   typedef enum logic {
      CNT_BIN = 1'b0,
      CNT_BCD = 1'b1
   } cnt_mode_e;

   localparam int unsigned DIGIT_W = 4;
   localparam logic [DIGIT_W-1:0] DEC_MAX = 4'd9;
endpackage

// File: rtl/pdiv_digit.sv
module pdiv_digit
   import pdiv_pkg::*;
(
   input  logic [DIGIT_W-1:0] d_in,
   input  cnt_mode_e          mode,
   input  logic               borrow_in,
   output logic [DIGIT_W-1:0] d_out,
   output logic               borrow_out
);
   always_comb begin
      d_out      = d_in;
      borrow_out = 1'b0;
      if (borrow_in) begin
         if (d_in == '0) begin
            d_out      = (mode == CNT_BCD) ? DEC_MAX : '1;
            borrow_out = 1'b1;
         end else begin
            d_out = d_in - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pdiv_next.sv
module pdiv_next
   import pdiv_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] cur,
   input  cnt_mode_e    mode,
   output logic [W-1:0] nxt
);
   localparam int unsigned NDIG = W / DIGIT_W;

   logic [NDIG:0] borrow;
   assign borrow[0] = 1'b1;

   generate
      if ((W % DIGIT_W) != 0 || W == 0) begin : g_bad_width
         $error("pdiv_next: W must be a nonzero multiple of 4");
      end
      for (genvar g = 0; g < NDIG; g++) begin : g_digit
         pdiv_digit u_digit (
            .d_in      (cur[g*DIGIT_W +: DIGIT_W]),
            .mode      (mode),
            .borrow_in (borrow[g]),
            .d_out     (nxt[g*DIGIT_W +: DIGIT_W]),
            .borrow_out(borrow[g+1])
         );
      end
   endgenerate
endmodule

// File: rtl/pdiv_outreg.sv
module pdiv_outreg (
   input  logic clk,
   input  logic rst,
   input  logic tc_n,
   output logic div_out
);
   always_ff @(posedge clk) begin
      if (rst)        div_out <= 1'b0;
      else if (!tc_n) div_out <= ~div_out;
   end

   AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      !tc_n |=> div_out != $past(div_out)); // R8
   AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
      tc_n |=> $stable(div_out)); // R8
endmodule

// File: rtl/pdiv_counter.sv
module pdiv_counter
   import pdiv_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bcd_mode,
   input  logic         fb_sel,
   input  logic         load_n_ext,
   input  logic [W-1:0] div_word,
   output logic         tc_n,
   output logic [W-1:0] count_q,
   output logic         div_out
);
   localparam logic [W-1:0] ZERO = '0;

   cnt_mode_e    mode;
   logic         pe_n;
   logic [W-1:0] cnt_next;

   generate
      if (W < 4 || (W % 4) != 0) begin : g_bad_w
         $error("pdiv_counter: W must be a multiple of 4, at least 4");
      end
   endgenerate

   assign mode = cnt_mode_e'(bcd_mode);
   assign tc_n = (count_q != ZERO);
   assign pe_n = fb_sel ? tc_n : load_n_ext;

   pdiv_next #(.W(W)) u_next (
      .cur (count_q),
      .mode(mode),
      .nxt (cnt_next)
   );

   always_ff @(posedge clk) begin
      if (rst)        count_q <= div_word;
      else if (!pe_n) count_q <= div_word;
      else            count_q <= cnt_next;
   end

   pdiv_outreg u_out (
      .clk    (clk),
      .rst    (rst),
      .tc_n   (tc_n),
      .div_out(div_out)
   );

   AST_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!fb_sel && !load_n_ext) |=> count_q == $past(div_word)); // R1
   AST_BIN_STEP: assert property (@(posedge clk) disable iff (rst)
      (!bcd_mode && pe_n) |=> count_q == $past(count_q) - 1'b1); // R2
   AST_FB_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (fb_sel && !tc_n) |=> count_q == $past(div_word)); // R4
   AST_BCD_UNITS: assert property (@(posedge clk) disable iff (rst)
      (bcd_mode && pe_n && count_q[3:0] == 4'd0) |=> count_q[3:0] == 4'd9); // R5
   AST_FB_ZERO: assert property (@(posedge clk) disable iff (rst)
      (fb_sel && div_word == ZERO && !tc_n) |=> !tc_n); // R6
endmodule

// File: tb/pdiv_counter_test.sv
module pdiv_counter_test;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bcd_mode = 1'b0;
   logic       fb_sel = 1'b0;
   logic       load_n_ext = 1'b1;
   logic [7:0] div_word = 8'd0;
   logic       tc_n;
   logic [7:0] count_q;
   logic       div_out;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   logic [7:0] m_cnt = 8'd0;
   logic       m_div = 1'b0;

   pdiv_counter uut (.*);

   always #(CLK_PER/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   function automatic logic [7:0] ref_dec(input logic [7:0] v, input logic bcd);
      int n;
      if (!bcd) return v - 8'd1;
      n = int'(v[7:4]) * 10 + int'(v[3:0]);
      n = (n == 0) ? 99 : n - 1;
      return {4'(n / 10), 4'(n % 10)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic b, input logic f, input logic ldn,
                       input logic [7:0] w, input string tag);
      logic pe;
      @(negedge clk);
      rst = r; bcd_mode = b; fb_sel = f; load_n_ext = ldn; div_word = w;
      @(posedge clk);
      if (r) begin
         m_cnt = w; m_div = 1'b0;
      end else begin
         pe = f ? (m_cnt != 8'd0) : ldn;
         m_div = m_div ^ (m_cnt == 8'd0);
         m_cnt = pe ? ref_dec(m_cnt, b) : w;
      end
      #(CLK_PER/4);
      check(tag, 32'(count_q), 32'(m_cnt), "count_q");
      check("R3", 32'(tc_n), 32'(m_cnt != 8'd0), "tc_n");
      check("R8", 32'(div_out), 32'(m_div), "div_out");
   endtask

   initial begin
      int last_tc;
      int gap;
      logic [7:0] w;
      logic b, f, ldn;
      void'($urandom(32'h5eed_0042));

      // R7: reset loads word and clears divided output
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'd5, "R7");
      for (int i = 1; i <= 6; i++) begin
         step(1'b0, 1'b0, 1'b1, 1'b1, 8'd5, "R7");
         if (i == 5) check("R7", 32'(tc_n), 32'd0, "tc_n low after N edges");
         if (i == 6) check("R7", 32'(count_q), 32'd5, "reload at edge N+1");
      end

      // R4: divide-by-100 with word 99
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'd99, "R4");
      last_tc = -1;
      for (int i = 0; i < 260; i++) begin
         step(1'b0, 1'b0, 1'b1, 1'b1, 8'd99, "R4");
         if (!tc_n) begin
            if (last_tc >= 0) begin
               gap = i - last_tc;
               check("R4", 32'(gap), 32'd100, "terminal count spacing");
            end
            last_tc = i;
         end
      end

      // R6: word zero keeps terminal count low
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'd0, "R6");
      for (int i = 0; i < 8; i++) begin
         step(1'b0, 1'b0, 1'b1, 1'b1, 8'd0, "R6");
         check("R6", 32'(tc_n), 32'd0, "tc_n held low");
      end

      // R2: binary wrap 00 -> FF in free-running mode
      step(1'b0, 1'b0, 1'b0, 1'b0, 8'd1, "R1");
      step(1'b0, 1'b0, 1'b0, 1'b1, 8'd1, "R2");
      step(1'b0, 1'b0, 1'b0, 1'b1, 8'd1, "R2");
      check("R2", 32'(count_q), 32'hFF, "binary wrap");

      // R5: BCD borrow 10 -> 09 and wrap 00 -> 99
      step(1'b0, 1'b1, 1'b0, 1'b0, 8'h10, "R1");
      step(1'b0, 1'b1, 1'b0, 1'b1, 8'h10, "R5");
      check("R5", 32'(count_q), 32'h09, "tens borrow");
      step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R1");
      step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, "R5");
      check("R5", 32'(count_q), 32'h99, "decimal wrap");

      // R9: external pin held low while feedback selected
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'd20, "R9");
      for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 8'd20, "R9");

      // Random mix
      b = 1'b0; f = 1'b1; w = 8'd7;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 39) == 0) begin
            b = 1'($urandom_range(0, 1));
            f = 1'($urandom_range(0, 1));
            if (b) w = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            else   w = 8'($urandom_range(0, 255));
            step(1'b1, b, f, 1'b1, w, "R7");
         end else begin
            ldn = ($urandom_range(0, 15) != 0);
            step(1'b0, b, f, ldn, w,
                 (!f && !ldn) ? "R1" : (f ? (b ? "R5" : "R4") : (b ? "R5" : "R2")));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule